// File: doc/BRIEF.md
# Buffered Byte Serial Port (Master or Slave)

This block is a byte-wide synchronous serial port. One control bit decides whether it drives the serial clock as a master or follows a clock from a remote master as a slave. Software sees two locations: a data location, where a write queues a byte for sending and a read returns the last byte received, and a combined control/status location. The status holds a transmit-empty flag, a receive-full flag and an overflow flag. The control holds the role bit and a two-bit rate select.

Outgoing bytes pass through a one-deep holding buffer into the shift register. When the shifter is free, the byte moves in at once, so software can queue the next byte while the current one is still on the wire. In master mode this gives back-to-back bytes with no gap. The shift register sends MSB first in clock-idle-low timing and takes in the partner's byte at the same time. Each finished byte is copied to a receive register. In slave mode the external clock, data and select lines are first passed through a two-flop synchronizer, so the whole block runs from one bus clock.

Top module: `spi_dbuf`

## Requirements
- R1: After reset the status reads 0x20: transmit empty set, receive full and overflow clear, slave role, rate select 0. SCK is low.
- R2: Location 1 (bus_sel=1) reads {rxfull, overflow, txempty, 0, 0, rate[1:0], master} from bit 7 down to bit 0. A write there loads master from bit 0 and rate from bits 2:1. Location 0 is the data register.
- R3: A data write while the shifter is idle loads the byte straight into the shifter. Transmit-empty reads 1 in the next cycle, and in master mode the transfer starts. Any data write made while a byte is shifting clears transmit-empty.
- R4: In master mode the SCK period is 2, 8, 32 or 128 bus cycles for rate select 0, 1, 2 or 3. SCK idles low and gives 8 pulses per byte. Only the master role produces SCK.
- R5: Data goes out MSB first. MOSI changes only after a falling SCK edge, and MISO is sampled on the rising edge, so the partner's byte comes in during the same 8 pulses.
- R6: A byte ends on its eighth falling edge, 8 x divisor cycles after it started. In that cycle receive-full sets and the received byte is copied to the data register.
- R7: If a byte is waiting in the buffer when the current byte ends, it enters the shifter in that same cycle. Transmit-empty sets again, and the next byte's first rising edge follows half a period later.
- R8: Receive-full clears only when a status read made while it is set is followed by a data read. A data read on its own leaves the flag set.
- R9: If a byte ends while receive-full is still set, overflow sets, the earlier byte stays in the data register and the new byte is dropped. The clear sequence of R8 also clears overflow.
- R10: In slave mode a data write produces no SCK. While select is low the block shifts on the synchronized external SCK, presents its byte MSB first on MISO, and sets receive-full with the byte taken from MOSI.
- R11: If slave select goes high before a byte is complete, the partial bits are discarded and no receive-full is raised. The next byte is counted from its first bit.
- R12: In slave mode, a byte sent with an SCK period of two bus cycles (the fastest master rate) is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | 0 selects data, 1 selects control/status |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the selected location |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock from a remote master |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench builds the block with its default WIDTH of 8, which fixes the status layout and the 16 half-period count per byte. It then sets all four rate selects in turn. The slowest rate takes 1024 bus cycles per byte, which brings the divider's widest count and the idle-to-busy restart within reach. The same default width lets the slave tests drive SCK at a two-cycle period, so the synchronizer latency is exercised at its limit.

// File: rtl/spi_dbuf.sv
module spi_dbuf #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_sel,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic             sck_o,
  input  logic             sck_i,
  output logic             mosi_o,
  input  logic             mosi_i,
  output logic             miso_o,
  input  logic             miso_i,
  input  logic             ss_n_i
);
  localparam int EW = $clog2(2*WIDTH);
  localparam int BW = $clog2(WIDTH+1);

  logic             mst, txe, rxf, ovf, armed, busy, sck_r, cap;
  logic [1:0]       baud;
  logic [WIDTH-1:0] txb, sh, rxd;
  logic [5:0]       hcnt;
  logic [EW-1:0]    ecnt;
  logic [BW-1:0]    bcnt;
  logic [2:0]       sck_q;
  logic [1:0]       mosi_q, ss_q;

  wire wr_d = bus_wr & ~bus_sel;
  wire wr_c = bus_wr &  bus_sel;
  wire rd_d = bus_rd & ~bus_sel;
  wire rd_s = bus_rd &  bus_sel;

  wire [6:0] half = 7'd1 << {baud, 1'b0};
  wire tick   = busy & mst & ({1'b0, hcnt} == half - 7'd1);
  wire s_rise = ~mst & ~ss_q[1] &  sck_q[1] & ~sck_q[2];
  wire s_fall = ~mst & ~ss_q[1] & ~sck_q[1] &  sck_q[2];
  wire rise   = (tick & ~sck_r) | s_rise;
  wire fall   = (tick &  sck_r) | s_fall;
  wire last   = mst ? (ecnt == EW'(2*WIDTH-1)) : (bcnt == BW'(WIDTH));
  wire done   = fall & last;
  wire idle   = (mst ? ~busy : (bcnt == '0)) | (done & txe);
  wire start  = wr_d & idle;
  wire load   = start | (done & ~txe);
  wire clr    = rd_d & armed;
  wire [WIDTH-1:0] rx_word = {sh[WIDTH-2:0], cap};
  wire [7:0] stat = {rxf, ovf, txe, 2'b00, baud, mst};

  assign bus_rdata = bus_sel ? WIDTH'(stat) : rxd;
  assign sck_o     = sck_r;
  assign mosi_o    = mst & sh[WIDTH-1];
  assign miso_o    = ~mst & sh[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst <= 1'b0;  baud <= '0;  txb <= '0;  sh <= '0;  rxd <= '0;
      txe <= 1'b1;  rxf <= 1'b0; ovf <= 1'b0; armed <= 1'b0;
      busy <= 1'b0; sck_r <= 1'b0; cap <= 1'b0;
      hcnt <= '0;   ecnt <= '0;  bcnt <= '0;
      sck_q <= '0;  mosi_q <= '0; ss_q <= '1;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      mosi_q <= {mosi_q[0], mosi_i};
      ss_q   <= {ss_q[0], ss_n_i};

      if (wr_c) begin
        mst  <= bus_wdata[0];
        baud <= bus_wdata[2:1];
      end
      if (wr_d) begin
        txb <= bus_wdata;
        txe <= 1'b0;
      end

      if (rd_s && rxf) armed <= 1'b1;
      if (clr) begin
        rxf <= 1'b0; ovf <= 1'b0; armed <= 1'b0;
      end
      if (done) begin
        if (rxf && !clr) ovf <= 1'b1;
        else begin
          rxd <= rx_word;
          rxf <= 1'b1;
        end
      end

      if (rise) cap <= mst ? miso_i : mosi_q[1];
      if (fall) sh <= rx_word;
      if (load) begin
        sh  <= start ? bus_wdata : txb;
        txe <= 1'b1;
      end

      if (mst) begin
        if (start) begin
          busy <= 1'b1; hcnt <= '0; ecnt <= '0; sck_r <= 1'b0;
        end else if (tick) begin
          hcnt  <= '0;
          sck_r <= ~sck_r;
          ecnt  <= last ? '0 : ecnt + EW'(1);
          if (done && txe) busy <= 1'b0;
        end else if (busy) begin
          hcnt <= hcnt + 6'd1;
        end
      end else begin
        if (ss_q[1])   bcnt <= '0;
        else if (rise) bcnt <= bcnt + BW'(1);
        else if (done) bcnt <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_sel,
  input logic             sck_o,
  input logic             busy,
  input logic             idle,
  input logic             done,
  input logic             armed,
  input logic             txe,
  input logic             rxf,
  input logic             ovf,
  input logic [WIDTH-1:0] rxd,
  input logic [WIDTH-1:0] rx_word
);
  wire clr_now = bus_rd && !bus_sel && armed;

  a_r4_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_o);

  a_r3_txe_after_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel && idle) |=> txe);

  a_r6_rx_copy_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(rxf && !clr_now)) |=> (rxf && rxd == $past(rx_word)));

  a_r9_overflow_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rxf && !clr_now) |=> (ovf && $stable(rxd)));

  a_r8_rxf_falls_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxf) |-> $past(bus_rd && !bus_sel));
endmodule

bind spi_dbuf spi_dbuf_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
  .sck_o(sck_o), .busy(busy), .idle(idle), .done(done), .armed(armed),
  .txe(txe), .rxf(rxf), .ovf(ovf), .rxd(rxd), .rx_word(rx_word)
);

// File: tb/spi_dbuf_tb.sv
module spi_dbuf_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, bus_wr = 0, bus_rd = 0, bus_sel = 1;
  logic [7:0] bus_wdata = 0;
  wire  [7:0] bus_rdata;
  wire  sck_o, mosi_o, miso_o;
  logic sck_i = 0, mosi_i = 0, ss_n_i = 1;
  logic miso_i;

  spi_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  int tests = 0, fails = 0;
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // remote slave partner for master tests
  logic [7:0] slv_bytes [0:15];
  int sidx = 0, fb = 0, nb = 0;
  logic [7:0] got = 0;
  logic [7:0] mosi_seen [$];
  assign miso_i = slv_bytes[sidx][7-fb];
  always @(posedge sck_o) if (rst_n) begin
    got = {got[6:0], mosi_o};
    nb++;
    if (nb == 8) begin mosi_seen.push_back(got); nb = 0; end
  end
  always @(negedge sck_o) if (rst_n) begin
    if (fb == 7) begin fb = 0; sidx++; end else fb++;
  end

  // behavioural reference for master mode
  bit model_on = 0;
  bit m_mst = 0, m_busy = 0, m_txe = 1, m_rxf = 0, m_ovf = 0, m_arm = 0, m_pend = 0;
  logic [1:0] m_baud = 0;
  logic [7:0] m_rx = 0;
  int m_div = 2, m_t = 0, m_sidx = 0;
  bit wd, wc, rdd, rds, clr, rxf0, fin;
  always @(posedge clk) if (rst_n) begin
    wd = bus_wr && !bus_sel; wc = bus_wr && bus_sel;
    rdd = bus_rd && !bus_sel; rds = bus_rd && bus_sel;
    clr = rdd && m_arm; rxf0 = m_rxf; fin = 0;
    if (m_busy) begin m_t++; if (m_t == 8*m_div) fin = 1; end
    if (rds && rxf0) m_arm = 1;
    if (clr) begin m_rxf = 0; m_ovf = 0; m_arm = 0; end
    if (fin) begin
      if (rxf0 && !clr) m_ovf = 1;
      else begin m_rx = slv_bytes[m_sidx]; m_rxf = 1; end
      m_sidx++;
      if (m_pend) begin m_pend = 0; m_t = 0; m_txe = 1; end
      else m_busy = 0;
    end
    if (wc) begin
      m_mst = bus_wdata[0]; m_baud = bus_wdata[2:1];
      m_div = 2 << (2*int'(bus_wdata[2:1]));
    end
    if (wd) begin
      if (!m_busy) begin m_busy = 1; m_t = 0; m_txe = 1; end
      else begin m_pend = 1; m_txe = 0; end
    end
  end
  always @(posedge clk) if (model_on) begin
    #2;
    check("R4 sck per cycle", sck_o, m_busy ? (m_t / (m_div/2)) % 2 : 0);
    if (bus_sel) check("R6 status per cycle", bus_rdata, {m_rxf, m_ovf, m_txe, 2'b00, m_baud, m_mst});
    else         check("R9 data per cycle", bus_rdata, m_rx);
  end

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_sel = 1; #1;
  endtask
  task automatic rd(logic sel, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_sel = sel; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_sel = 1; #1;
  endtask
  task automatic slave_xfer(logic [7:0] m, int half, output logic [7:0] g);
    @(negedge clk); ss_n_i = 0;
    repeat (half) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = m[i];
      repeat (half) @(negedge clk);
      g[i] = miso_o; sck_i = 1;
      repeat (half) @(negedge clk);
      sck_i = 0;
    end
    repeat (half + 3) @(negedge clk);
    ss_n_i = 1;
    repeat (4) @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] s, d, g;
    logic [7:0] sent [8] = '{8'h3C, 8'hC7, 8'h81, 8'h42, 8'h11, 8'h22, 8'h5E, 8'hE1};
    bit quiet;
    for (int k = 0; k < 16; k++) slv_bytes[k] = 8'(k*37 + 90);
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    check("R1 status after reset", bus_rdata, 8'h20);
    check("R1 sck after reset", sck_o, 0);
    model_on = 1;

    wr(1, 8'h01);
    check("R2 control readback", bus_rdata, 8'h21);

    wr(0, 8'h3C);
    check("R3 txempty after idle write", bus_rdata[5], 1);
    repeat (18) @(negedge clk); #1;
    check("R6 rxfull at byte end", bus_rdata[7], 1);
    rd(1, s); rd(0, d);
    check("R6 received byte", d, slv_bytes[0]);
    check("R8 rxfull cleared", bus_rdata[7], 0);

    wr(0, 8'hC7);
    repeat (18) @(negedge clk);
    rd(0, d);
    check("R8 data read alone keeps rxfull", bus_rdata[7], 1);
    rd(1, s); rd(0, d);
    check("R8 byte after clear", d, slv_bytes[1]);
    check("R8 rxfull cleared after sequence", bus_rdata[7], 0);

    wr(1, 8'h03);
    check("R2 rate readback", bus_rdata, 8'h23);
    wr(0, 8'h81); wr(0, 8'h42);
    check("R7 txempty cleared while busy", bus_rdata[5], 0);
    repeat (64) @(negedge clk); #1;
    check("R7 txempty set at reload", bus_rdata[5], 1);
    check("R7 first byte landed", bus_rdata[7], 1);
    rd(1, s); rd(0, d);
    check("R7 first byte", d, slv_bytes[2]);
    repeat (66) @(negedge clk);
    rd(1, s); rd(0, d);
    check("R7 second byte", d, slv_bytes[3]);

    wr(1, 8'h01);
    wr(0, 8'h11); repeat (18) @(negedge clk);
    wr(0, 8'h22); repeat (18) @(negedge clk); #1;
    check("R9 overflow flags", bus_rdata[7:6], 2'b11);
    rd(1, s); rd(0, d);
    check("R9 older byte kept", d, slv_bytes[4]);
    check("R9 flags cleared", bus_rdata[7:6], 2'b00);

    wr(1, 8'h05); wr(0, 8'h5E); repeat (258) @(negedge clk);
    rd(1, s); rd(0, d);
    check("R4 rate 2 byte", d, slv_bytes[6]);
    wr(1, 8'h07); wr(0, 8'hE1); repeat (1026) @(negedge clk);
    rd(1, s); rd(0, d);
    check("R4 rate 3 byte", d, slv_bytes[7]);

    check("R5 bytes seen on MOSI", mosi_seen.size(), 8);
    for (int k = 0; k < 8 && k < mosi_seen.size(); k++)
      check("R5 MOSI byte", mosi_seen[k], sent[k]);

    @(negedge clk); model_on = 0;
    wr(1, 8'h00);
    wr(0, 8'h96);
    check("R10 slave txempty after load", bus_rdata, 8'h20);
    quiet = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sck_o !== 1'b0) quiet = 0;
    end
    check("R10 no SCK in slave mode", quiet, 1);

    slave_xfer(8'h5B, 4, g);
    check("R10 MISO byte", g, 8'h96);
    rd(1, s);
    check("R10 slave rxfull", s[7], 1);
    rd(0, d);
    check("R10 slave received", d, 8'h5B);

    slave_xfer(8'hC3, 1, g);
    rd(1, s);
    check("R12 fast SCK rxfull", s[7], 1);
    rd(0, d);
    check("R12 fast SCK byte", d, 8'hC3);

    @(negedge clk); ss_n_i = 0;
    for (int i = 7; i >= 5; i--) begin
      mosi_i = 1'b1;
      repeat (2) @(negedge clk); sck_i = 1;
      repeat (2) @(negedge clk); sck_i = 0;
    end
    repeat (4) @(negedge clk); ss_n_i = 1;
    repeat (8) @(negedge clk); #1;
    check("R11 no rxfull after partial", bus_rdata[7], 0);
    slave_xfer(8'h81, 2, g);
    rd(1, s);
    check("R11 rxfull after full byte", s[7], 1);
    rd(0, d);
    check("R11 byte after partial", d, 8'h81);

    finish_run();
  end
endmodule